// File: doc/BRIEF.md
# Block-Reuse Scoring Loop Sequencer

This block drives the control side of a block-parallel hidden Markov model scoring engine. It does no arithmetic. It steps through a five-level loop nest and, on every cycle, raises the strobes and index outputs that tell the datapath what to fetch and what to do.

The outermost loop walks the models in groups of `cfg_group`. Inside each group it walks the frames in blocks of `cfg_block`. Within one block, every model of the group is scored against the same stored frames, so each block of feature vectors is fetched once per group and not once per model.

Reads go over a double-width bus that carries two values per beat:

- a block of feature vectors costs `cfg_block*cfg_dims/2` beats;
- a mean/weight parameter pair costs one beat.

Per state the sequencer spends three kinds of cycle, in this order:

- one bias cycle;
- one transition cycle, in which the self and entry transitions share the beat;
- one cycle per dimension.

A run starts with a pulse on `start`. It finishes with a single `done` pulse.

Top module: `hmm_block_sequencer`

## Requirements
- R1: After reset, and while idle, `busy`, `done` and every load, accumulate, copy and score strobe are 0.
- R2: Each frame block begins with exactly `cfg_block*cfg_dims/2` consecutive cycles with `feat_ld`=1. In these cycles `feat_slot` counts 0 upward and `feat_addr` equals `block_base*cfg_dims/2 + feat_slot`.
- R3: For each state, the cycles run in this order: one cycle with `ld_bias`=1, then one with `ld_self`=1, then `cfg_dims` cycles with `ld_pair`=1 in which `idx_dim` runs 0 to `cfg_dims-1`. At most one of `feat_ld`, `ld_bias`, `ld_self`, `ld_pair` is high in any cycle.
- R4: `ld_init` is high only in bias cycles, and only when `block_base` is 0.
- R5: `ld_cross` is high only in transition cycles, and only when `idx_state` is nonzero.
- R6: The bus and pipeline strobes line up as follows:
  - `acc_start` is high in the first pair cycle of a state;
  - `copy_stb` is high in the last pair cycle;
  - `score_en` is high in the cycle after each `copy_stb`.
- R7: The loop order from fastest to slowest is dimension, state, model within group, frame block, model group. `idx_model` equals the group base plus the model offset, and `block_base` steps by `cfg_block` from 0.
- R8: `frame_valid` bit i is 1 exactly when i < `cfg_block` and `block_base + i` < `cfg_frames`. A final block that runs past the last frame is still loaded, with its excess slots masked.
- R9: `model_valid` is 1 exactly when `idx_model` < `cfg_models`. The last group is always run at full size.
- R10: One run keeps `busy` high for exactly ceil(V/L)·(P·M/2 + (2+P)·L·N)·ceil(T/M) cycles. Here N=`cfg_states`, P=`cfg_dims`, M=`cfg_block`, L=`cfg_group`, T=`cfg_frames` and V=`cfg_models`.
- R11: `done` is high for exactly one cycle, immediately after the last busy cycle, and the block is idle after that. A `start` pulse while busy has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled when idle) |
| cfg_states | input | CW | Number of states per model, at least 1 |
| cfg_dims | input | CW | Feature dimension, at least 1 |
| cfg_block | input | CW | Frames per block, even, 2..MAX_M |
| cfg_group | input | CW | Models per group, at least 1 |
| cfg_frames | input | CW | Total frames, at least 1 |
| cfg_models | input | CW | Total models, at least 1 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| feat_ld | output | 1 | Feature beat load into frame store |
| feat_slot | output | 2*CW | Beat index within the frame store |
| feat_addr | output | 2*CW | Feature RAM beat address |
| ld_pair | output | 1 | Mean/weight pair fetch |
| ld_bias | output | 1 | State bias fetch |
| ld_init | output | 1 | Initial-score fetch (first block only) |
| ld_self | output | 1 | Self-transition fetch |
| ld_cross | output | 1 | Entry-transition fetch |
| acc_start | output | 1 | Restart accumulators |
| copy_stb | output | 1 | Move accumulated results to scorer input |
| score_en | output | 1 | Scorer update enable |
| idx_model | output | CW | Current model index |
| idx_state | output | CW | Current state index |
| idx_dim | output | CW | Current dimension index |
| block_base | output | CW | First frame index of current block |
| model_valid | output | 1 | Current model lies below cfg_models |
| frame_valid | output | MAX_M | Per-slot frame validity mask |

## Verification
The assertions assume that the six configuration inputs are held steady from the `start` pulse to `done`. They also assume the legal ranges are kept: every count is at least 1, and `cfg_block` is even and no larger than MAX_M. The bench writes each configuration while the block is idle and changes it only between runs. All configurations it uses are legal, and several of them leave a partial final block, a partial final group, or both. It also raises `start` in the middle of one run to confirm that the sequence is unaffected.

// File: rtl/hmm_seq_pkg.sv
package hmm_seq_pkg;
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_FEAT  = 3'd1,
      PH_BIAS  = 3'd2,
      PH_TRANS = 3'd3,
      PH_DIM   = 3'd4,
      PH_FIN   = 3'd5
   } phase_t;
endpackage

// File: rtl/hmm_step_ctr.sv
module hmm_step_ctr #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   input  logic [W-1:0] limit,
   output logic [W-1:0] count,
   output logic         last
);
   assign last = (count == limit - W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (clr)
         count <= '0;
      else if (inc)
         count <= last ? '0 : count + W'(1);
   end
endmodule

// File: rtl/hmm_frame_mask.sv
module hmm_frame_mask #(
   parameter int CW    = 16,
   parameter int MAX_M = 8,
   parameter bit MASK_EN = 1'b1
) (
   input  logic [CW-1:0]    base,
   input  logic [CW-1:0]    frames,
   input  logic [CW-1:0]    block,
   output logic [MAX_M-1:0] mask
);
   localparam int XW = CW + 1;

   for (genvar i = 0; i < MAX_M; i++) begin : g_slot
      if (MASK_EN) begin : g_masked
         logic [XW-1:0] pos;
         assign pos = {1'b0, base} + XW'(i);
         assign mask[i] = (XW'(i) < {1'b0, block}) && (pos < {1'b0, frames});
      end else begin : g_plain
         assign mask[i] = (XW'(i) < {1'b0, block});
      end
   end
endmodule

// File: rtl/hmm_block_sequencer.sv
module hmm_block_sequencer
   import hmm_seq_pkg::*;
#(
   parameter int CW      = 16,
   parameter int MAX_M   = 8,
   parameter bit MASK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CW-1:0]     cfg_states,
   input  logic [CW-1:0]     cfg_dims,
   input  logic [CW-1:0]     cfg_block,
   input  logic [CW-1:0]     cfg_group,
   input  logic [CW-1:0]     cfg_frames,
   input  logic [CW-1:0]     cfg_models,
   output logic              busy,
   output logic              done,
   output logic              feat_ld,
   output logic [2*CW-1:0]   feat_slot,
   output logic [2*CW-1:0]   feat_addr,
   output logic              ld_pair,
   output logic              ld_bias,
   output logic              ld_init,
   output logic              ld_self,
   output logic              ld_cross,
   output logic              acc_start,
   output logic              copy_stb,
   output logic              score_en,
   output logic [CW-1:0]     idx_model,
   output logic [CW-1:0]     idx_state,
   output logic [CW-1:0]     idx_dim,
   output logic [CW-1:0]     block_base,
   output logic              model_valid,
   output logic [MAX_M-1:0]  frame_valid
);
   localparam int DW = 2 * CW;
   localparam int XW = CW + 1;

   if (CW < 4) begin : g_bad_cw
      $error("hmm_block_sequencer: CW must be at least 4");
   end
   if (MAX_M < 2) begin : g_bad_m
      $error("hmm_block_sequencer: MAX_M must be at least 2");
   end

   phase_t          phase;
   logic [CW-1:0]   group_base;
   logic [CW-1:0]   model_ofs;
   logic [DW-1:0]   feat_beats;
   logic [DW-1:0]   base_word;
   logic            feat_last, dim_last, st_last, mi_last;
   logic            blk_end, grp_end, dim_wrap, st_wrap, loop_clr;

   assign feat_beats = DW'((DW'(cfg_block) * DW'(cfg_dims)) >> 1);
   assign base_word  = DW'((DW'(block_base) * DW'(cfg_dims)) >> 1);

   assign dim_wrap = (phase == PH_DIM) && dim_last;
   assign st_wrap  = dim_wrap && st_last;
   assign loop_clr = (phase == PH_IDLE) || (phase == PH_FEAT);

   hmm_step_ctr #(.W(DW)) u_feat (
      .clk(clk), .rst_n(rst_n),
      .clr(phase != PH_FEAT), .inc(phase == PH_FEAT),
      .limit(feat_beats), .count(feat_slot), .last(feat_last));

   hmm_step_ctr #(.W(CW)) u_dim (
      .clk(clk), .rst_n(rst_n),
      .clr(phase != PH_DIM), .inc(phase == PH_DIM),
      .limit(cfg_dims), .count(idx_dim), .last(dim_last));

   hmm_step_ctr #(.W(CW)) u_state (
      .clk(clk), .rst_n(rst_n),
      .clr(loop_clr), .inc(dim_wrap),
      .limit(cfg_states), .count(idx_state), .last(st_last));

   hmm_step_ctr #(.W(CW)) u_model (
      .clk(clk), .rst_n(rst_n),
      .clr(loop_clr), .inc(st_wrap),
      .limit(cfg_group), .count(model_ofs), .last(mi_last));

   hmm_frame_mask #(.CW(CW), .MAX_M(MAX_M), .MASK_EN(MASK_EN)) u_mask (
      .base(block_base), .frames(cfg_frames), .block(cfg_block),
      .mask(frame_valid));

   assign blk_end = ({1'b0, block_base} + {1'b0, cfg_block}) >= {1'b0, cfg_frames};
   assign grp_end = ({1'b0, group_base} + {1'b0, cfg_group}) >= {1'b0, cfg_models};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         block_base <= '0;
         group_base <= '0;
         score_en   <= 1'b0;
      end else begin
         score_en <= copy_stb;
         case (phase)
            PH_IDLE: if (start) begin
               phase      <= PH_FEAT;
               block_base <= '0;
               group_base <= '0;
            end
            PH_FEAT:  if (feat_last) phase <= PH_BIAS;
            PH_BIAS:  phase <= PH_TRANS;
            PH_TRANS: phase <= PH_DIM;
            PH_DIM: if (dim_last) begin
               if (st_last && mi_last) begin
                  if (blk_end) begin
                     if (grp_end) begin
                        phase <= PH_FIN;
                     end else begin
                        group_base <= group_base + cfg_group;
                        block_base <= '0;
                        phase      <= PH_FEAT;
                     end
                  end else begin
                     block_base <= block_base + cfg_block;
                     phase      <= PH_FEAT;
                  end
               end else begin
                  phase <= PH_BIAS;
               end
            end
            PH_FIN:   phase <= PH_IDLE;
            default:  phase <= PH_IDLE;
         endcase
      end
   end

   assign busy      = (phase == PH_FEAT) || (phase == PH_BIAS) ||
                      (phase == PH_TRANS) || (phase == PH_DIM);
   assign done      = (phase == PH_FIN);
   assign feat_ld   = (phase == PH_FEAT);
   assign feat_addr = base_word + feat_slot;
   assign ld_bias   = (phase == PH_BIAS);
   assign ld_init   = ld_bias && (block_base == '0);
   assign ld_self   = (phase == PH_TRANS);
   assign ld_cross  = ld_self && (idx_state != '0);
   assign ld_pair   = (phase == PH_DIM);
   assign acc_start = ld_pair && (idx_dim == '0);
   assign copy_stb  = dim_wrap;
   assign idx_model = group_base + model_ofs;

   logic [XW-1:0] model_x;
   assign model_x     = {1'b0, group_base} + {1'b0, model_ofs};
   assign model_valid = model_x < {1'b0, cfg_models};
endmodule

// File: rtl/hmm_seq_checker.sv
module hmm_seq_checker #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          feat_ld,
   input logic          ld_pair,
   input logic          ld_bias,
   input logic          ld_init,
   input logic          ld_self,
   input logic          ld_cross,
   input logic          acc_start,
   input logic          copy_stb,
   input logic          score_en,
   input logic [CW-1:0] idx_dim
);
   assert_one_bus_user_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({feat_ld, ld_bias, ld_self, ld_pair}));

   assert_bias_then_self_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ld_bias |=> ld_self);

   assert_dim_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_pair && !copy_stb) |=> (ld_pair && idx_dim == $past(idx_dim) + CW'(1)));

   assert_init_in_bias_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ld_init |-> ld_bias);

   assert_cross_in_trans_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ld_cross |-> ld_self);

   assert_self_then_acc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ld_self |=> (ld_pair && acc_start));

   assert_score_follows_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      copy_stb |=> score_en);

   assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind hmm_block_sequencer hmm_seq_checker #(.CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
   .feat_ld(feat_ld), .ld_pair(ld_pair), .ld_bias(ld_bias),
   .ld_init(ld_init), .ld_self(ld_self), .ld_cross(ld_cross),
   .acc_start(acc_start), .copy_stb(copy_stb), .score_en(score_en),
   .idx_dim(idx_dim));

// File: tb/sim_hmm_block_sequencer.sv
`timescale 1ns/1ps
module sim_hmm_block_sequencer;
   localparam int CW    = 16;
   localparam int MAX_M = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [CW-1:0] cfg_states = 1, cfg_dims = 2, cfg_block = 2,
                  cfg_group = 1, cfg_frames = 1, cfg_models = 1;
   logic busy, done, feat_ld, ld_pair, ld_bias, ld_init, ld_self, ld_cross;
   logic acc_start, copy_stb, score_en, model_valid;
   logic [2*CW-1:0] feat_slot, feat_addr;
   logic [CW-1:0] idx_model, idx_state, idx_dim, block_base;
   logic [MAX_M-1:0] frame_valid;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int busy_cnt = 0;

   always #4 clk = ~clk;

   hmm_block_sequencer #(.CW(CW), .MAX_M(MAX_M)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_states(cfg_states), .cfg_dims(cfg_dims), .cfg_block(cfg_block),
      .cfg_group(cfg_group), .cfg_frames(cfg_frames), .cfg_models(cfg_models),
      .busy(busy), .done(done), .feat_ld(feat_ld), .feat_slot(feat_slot),
      .feat_addr(feat_addr), .ld_pair(ld_pair), .ld_bias(ld_bias),
      .ld_init(ld_init), .ld_self(ld_self), .ld_cross(ld_cross),
      .acc_start(acc_start), .copy_stb(copy_stb), .score_en(score_en),
      .idx_model(idx_model), .idx_state(idx_state), .idx_dim(idx_dim),
      .block_base(block_base), .model_valid(model_valid),
      .frame_valid(frame_valid));

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (busy) busy_cnt <= busy_cnt + 1;
      if (cyc > 150000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cyc);
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // One packed word of all strobes: {busy,done,feat_ld,bias,init,self,cross,pair,acc,copy,score}
   function automatic logic [10:0] strobes();
      return {busy, done, feat_ld, ld_bias, ld_init, ld_self, ld_cross,
              ld_pair, acc_start, copy_stb, score_en};
   endfunction

   function automatic logic [MAX_M-1:0] exp_mask(int bb, int m, int t);
      logic [MAX_M-1:0] r = '0;
      for (int i = 0; i < MAX_M; i++) r[i] = (i < m) && (bb + i < t);
      return r;
   endfunction

   task automatic run_cfg(input int n, input int p, input int m, input int l,
                          input int t, input int v, input int poke);
      int ngrp, nblk, expect_busy, k;
      logic prev_copy;
      ngrp = (v + l - 1) / l;
      nblk = (t + m - 1) / m;
      expect_busy = ngrp * (p * m / 2 + (2 + p) * l * n) * nblk;
      @(negedge clk);
      cfg_states = CW'(n); cfg_dims = CW'(p); cfg_block = CW'(m);
      cfg_group = CW'(l); cfg_frames = CW'(t); cfg_models = CW'(v);
      @(negedge clk);
      busy_cnt = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      prev_copy = 1'b0;
      k = 0;
      for (int g = 0; g < ngrp; g++) begin
         for (int b = 0; b < nblk; b++) begin
            for (int s = 0; s < p * m / 2; s++) begin
               // R2 feature beats; R11 start mid-run is ignored
               start = (k == poke);
               k++;
               chk("R2 strobes", 64'(strobes()), 64'({1'b1,1'b0,1'b1,7'b0, prev_copy}));
               chk("R2 slot", 64'(feat_slot), 64'(s));
               chk("R2 addr", 64'(feat_addr), 64'(b * m * p / 2 + s));
               chk("R8 mask", 64'(frame_valid), 64'(exp_mask(b * m, m, t)));
               chk("R7 block", 64'(block_base), 64'(b * m));
               prev_copy = 1'b0;
               @(negedge clk);
            end
            start = 1'b0;
            for (int mi = 0; mi < l; mi++) begin
               for (int j = 0; j < n; j++) begin
                  // R3/R4 bias cycle
                  chk("R4 bias", 64'(strobes()),
                      64'({1'b1,1'b0,1'b0,1'b1,(b == 0),1'b0,1'b0,1'b0,1'b0,1'b0,prev_copy}));
                  chk("R7 model", 64'(idx_model), 64'(g * l + mi));
                  chk("R9 valid", 64'(model_valid), 64'(g * l + mi < v));
                  chk("R7 state", 64'(idx_state), 64'(j));
                  prev_copy = 1'b0;
                  @(negedge clk);
                  // R5 transition cycle
                  chk("R5 trans", 64'(strobes()),
                      64'({1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,(j > 0),1'b0,1'b0,1'b0,1'b0}));
                  @(negedge clk);
                  for (int d = 0; d < p; d++) begin
                     // R3/R6 pair cycles
                     chk("R6 pair", 64'(strobes()),
                         64'({1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,(d == 0),(d == p - 1),prev_copy}));
                     chk("R3 dim", 64'(idx_dim), 64'(d));
                     prev_copy = (d == p - 1);
                     @(negedge clk);
                  end
               end
            end
         end
      end
      // R11 done one cycle after last busy cycle, score_en from last copy (R6)
      chk("R11 done", 64'(strobes()), 64'({1'b0,1'b1,8'b0,1'b1}));
      @(negedge clk);
      chk("R11 idle", 64'(strobes()), 64'(11'b0));
      chk("R10 busy cycles", 64'(busy_cnt), 64'(expect_busy));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset", 64'(strobes()), 64'(11'b0));
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle", 64'(strobes()), 64'(11'b0));
      run_cfg(2, 2, 2, 1, 4, 2, -1);
      run_cfg(3, 4, 4, 2, 6, 3, 3);     // partial block and group
      run_cfg(1, 1, 2, 1, 1, 1, -1);    // smallest
      run_cfg(2, 3, 2, 3, 3, 5, 1);     // odd dims, partial both
      run_cfg(2, 2, 8, 2, 8, 4, -1);    // full-width mask
      run_cfg(4, 2, 6, 1, 13, 2, 5);    // M not a power of two
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule